// File: doc/BRIEF.md
# Oversampled I2C Register-Access Slave

This block is an I2C slave that runs entirely in a fast system clock domain. It treats the bus clock and the incoming data line as plain sampled inputs. Both pass through a flop synchronizer. Bus events are found by comparing consecutive synchronized samples. The block never drives the bus clock. It pulls the data line low through a separate output, `sda_o`, where 0 means pull low and 1 means release; the board combines that output with the wire. The system clock must run at least ten times faster than SCL, which allows bus rates up to 400 kb/s.

After a START, the first byte selects the device. A configuration pin picks one of two 7-bit addresses. A write transfer loads the next byte into an internal register pointer. Every byte after that is written to the register file, and the pointer then advances. A read transfer returns the byte at the pointer and advances it. The read continues for as long as the master acknowledges.

The register-file side is a plain strobe port with no back-pressure. `reg_we` is a single-cycle pulse carrying `reg_addr` and `reg_wdata`. `reg_re` is a single-cycle pulse, and `reg_rdata` must be valid, combinationally from `reg_addr`, in that same cycle. The register file can never stall the bus side. It must accept or supply data in the strobe cycle.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_o` is 1 (released), and `reg_we` and `reg_re` are both 0.
- R2: START (SDA falling while SCL is high) restarts device selection at any point. STOP (SDA rising while SCL is high) abandons the transfer at any point. A data byte cut short by either is never written.
- R3: With `addr_sel`=0 the block answers 7-bit address 0x1C (select bytes 0x38 write, 0x39 read). With `addr_sel`=1 it answers 0x1D (0x3A, 0x3B). On a match it drives `sda_o` low through the 9th SCL clock.
- R4: On an address mismatch the block never pulls SDA low and issues no strobes until the next START.
- R5: In a write, the first byte after the select byte is acknowledged and loaded as the 8-bit register pointer, with no write strobe.
- R6: Each further written byte is acknowledged and produces one single-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments, wrapping from 0xFF to 0x00.
- R7: In a read (select LSB 1), each byte produces one single-cycle `reg_re` at the pointer, and the pointer then increments. The captured `reg_rdata` is shifted out MSB first on `sda_o`.
- R8: A master ACK (SDA low on the 9th clock of a read byte) starts the next read byte. A NACK makes the block release SDA with no further `reg_re`.
- R9: `sda_o` changes only while SCL is low.
- R10: The register pointer survives a repeated START, so a pointer write followed by a read select returns data from that pointer.
- R11: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_o | output | 1 | Data drive: 0 pulls low, 1 releases |
| addr_sel | input | 1 | Chooses between the two slave addresses |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle `reg_re` is high |
| reg_re | output | 1 | Single-cycle read strobe |

## Verification
A wrong bit count or a wrong receive phase shows up within one byte time: an acknowledge that is missing or misplaced on the 9th clock, or a write strobe with the wrong data. A corrupted pointer is not visible while it is being loaded. It shows at the register file on the next strobe, where a value lands at the wrong address or a read returns the wrong byte. A failure to leave the active states after a mismatch, NACK, STOP or mid-byte START shows as stray acknowledges or strobes during the traffic that follows. The bench therefore sends further bytes after each such event and checks the register-file contents and strobe counts.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_LOAD,
    ST_TX,
    ST_MACK,
    ST_MWAIT
  } slv_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_PTR,
    K_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // idle bus is high, so the chain resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] raw, syn, prev;

  assign raw = {sda_i, scl_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[p]),
      .q    (syn[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= syn;
  end

  logic scl_now, scl_was, sda_now, sda_was;
  assign scl_now = syn[0];
  assign scl_was = prev[0];
  assign sda_now = syn[1];
  assign sda_was = prev[1];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_was;
  assign scl_fall  = ~scl_now & scl_was;
  assign bus_start = scl_now & scl_was & sda_was & ~sda_now;
  assign bus_stop  = scl_now & scl_was & ~sda_was & sda_now;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter logic [DEV_W-1:0] ADDR_LO = 7'h1C,
  parameter logic [DEV_W-1:0] ADDR_HI = 7'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_sel,
  output logic              sda_o,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_re
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  slv_state_e        state;
  rx_kind_e          kind;
  logic [CNT_W-1:0]  cnt;
  logic              done;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] ptr;
  logic              rd_mode;
  logic              drv_q;
  logic              we_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [DEV_W-1:0]  own_addr;
  logic              load_now;

  assign own_addr = addr_sel ? ADDR_HI : ADDR_LO;
  assign load_now = (state == ST_LOAD) && !bus_start && !bus_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= K_DEV;
      cnt     <= '0;
      done    <= 1'b0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      drv_q   <= 1'b1;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      // pointer moves the cycle after the write strobe, so the strobe sees the old value
      if (we_q) ptr <= ptr + 1'b1;

      if (bus_start) begin
        state <= ST_RX;
        kind  <= K_DEV;
        cnt   <= '0;
        done  <= 1'b0;
        drv_q <= 1'b1;
      end else if (bus_stop) begin
        state <= ST_IDLE;
        done  <= 1'b0;
        drv_q <= 1'b1;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && !done) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
              if (cnt == LAST_BIT) done <= 1'b1;
            end else if (scl_fall && done) begin
              done <= 1'b0;
              cnt  <= '0;
              unique case (kind)
                K_DEV: begin
                  if (rx_sh[BYTE_W-1:1] == own_addr) begin
                    rd_mode <= rx_sh[0];
                    drv_q   <= 1'b0;
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr   <= rx_sh;
                  drv_q <= 1'b0;
                  state <= ST_ACK;
                end
                default: begin
                  we_q    <= 1'b1;
                  wdata_q <= rx_sh;
                  drv_q   <= 1'b0;
                  state   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              drv_q <= 1'b1;
              if (kind == K_DEV && rd_mode) begin
                state <= ST_LOAD;
              end else begin
                state <= ST_RX;
                kind  <= (kind == K_DEV) ? K_PTR : K_DATA;
              end
            end
          end
          ST_LOAD: begin
            tx_sh <= {reg_rdata[BYTE_W-2:0], 1'b0};
            drv_q <= reg_rdata[BYTE_W-1];
            ptr   <= ptr + 1'b1;
            cnt   <= '0;
            state <= ST_TX;
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                drv_q <= 1'b1;
                cnt   <= '0;
                state <= ST_MACK;
              end else begin
                drv_q <= tx_sh[BYTE_W-1];
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) state <= sda_s ? ST_IDLE : ST_MWAIT;
          end
          ST_MWAIT: begin
            if (scl_fall) state <= ST_LOAD;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_o     = drv_q;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = load_now;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [DEV_W-1:0] ADDR_LO     = 7'h1C,
  parameter logic [DEV_W-1:0] ADDR_HI     = 7'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  input  logic       addr_sel,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       reg_re
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  i2c_slv_engine #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .addr_sel (addr_sel),
    .sda_o    (sda_o),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_rdata(reg_rdata),
    .reg_re   (reg_re)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_o,
  input logic [7:0] reg_addr,
  input logic       reg_we,
  input logic       reg_re
);
  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_o) |-> !scl_i);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6
  we_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 8'd1);

  // R7
  re_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (reg_addr == $past(reg_addr) + 8'd1) && !reg_re);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_o   (sda_o),
  .reg_addr(reg_addr),
  .reg_we  (reg_we),
  .reg_re  (reg_re)
);

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;  // system clocks per SCL phase

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_o;
  logic       addr_sel = 1'b0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;
  logic       line;

  logic [7:0] mem [256];
  int we_cnt = 0, re_cnt = 0, hi_changes = 0;
  int checks = 0, errors = 0;
  logic sda_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = sda_m & sda_o;

  i2c_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_o(sda_o),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
    if (rst_n) begin
      if (reg_we) we_cnt <= we_cnt + 1;
      if (reg_re) re_cnt <= re_cnt + 1;
      if (sda_o != sda_prev && scl_m) hi_changes <= hi_changes + 1;
    end
    sda_prev <= sda_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q/2);
    acked = !line;
    wait_clk(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q/2);
      b[i] = line;
      wait_clk(Q/2);
      scl_m = 1'b0;
    end
    sda_m = ack ? 1'b0 : 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic t_reset;
    check(sda_o === 1'b1, "R1 sda_o released", sda_o, 1);
    check(reg_we === 1'b0 && reg_re === 1'b0, "R1 strobes idle", {reg_we, reg_re}, 0);
  endtask

  task automatic t_write_lo;
    bit a; int w0;
    addr_sel = 1'b0;
    bus_start;
    send_byte(8'h38, a); check(a, "R3 ack on 0x38 sel0", a, 1);
    w0 = we_cnt;
    send_byte(8'h10, a); check(a, "R5 pointer byte ack", a, 1);
    check(we_cnt == w0, "R5 no write on pointer", we_cnt, w0);
    send_byte(8'hA5, a); check(a, "R6 data ack", a, 1);
    send_byte(8'h5A, a);
    bus_stop;
    check(mem[8'h10] == 8'hA5, "R6 first byte at pointer", mem[8'h10], 8'hA5);
    check(mem[8'h11] == 8'h5A, "R6 second byte at pointer+1", mem[8'h11], 8'h5A);
    check(we_cnt == w0 + 2, "R6 one strobe per byte", we_cnt, w0 + 2);
  endtask

  task automatic t_read;
    bit a; logic [7:0] b; int r0;
    bus_start;
    send_byte(8'h38, a);
    send_byte(8'h10, a);
    bus_start;
    send_byte(8'h39, a); check(a, "R3 ack on read select", a, 1);
    r0 = re_cnt;
    recv_byte(1'b1, b); check(b == 8'hA5, "R7 R10 read at kept pointer", b, 8'hA5);
    recv_byte(1'b0, b); check(b == 8'h5A, "R8 next byte after master ack", b, 8'h5A);
    wait_clk(4 * Q);
    check(re_cnt == r0 + 2, "R8 no read after nack", re_cnt, r0 + 2);
    check(sda_o === 1'b1, "R8 released after nack", sda_o, 1);
    bus_stop;
  endtask

  task automatic t_mismatch;
    bit a; int w0, r0;
    addr_sel = 1'b0;
    w0 = we_cnt; r0 = re_cnt;
    bus_start;
    send_byte(8'h3A, a); check(!a, "R4 no ack on 0x3A with sel0", a, 0);
    send_byte(8'h20, a); check(!a, "R4 following byte ignored", a, 0);
    send_byte(8'h77, a);
    bus_stop;
    check(mem[8'h20] == 8'h00 && we_cnt == w0 && re_cnt == r0, "R4 no strobes",
          we_cnt - w0 + re_cnt - r0, 0);
  endtask

  task automatic t_sel_hi;
    bit a;
    addr_sel = 1'b1;
    bus_start;
    send_byte(8'h38, a); check(!a, "R3 0x38 refused with sel1", a, 0);
    bus_stop;
    bus_start;
    send_byte(8'h3A, a); check(a, "R3 ack on 0x3A sel1", a, 1);
    send_byte(8'hFF, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_stop;
    check(mem[8'hFF] == 8'h11, "R6 write at 0xFF", mem[8'hFF], 8'h11);
    check(mem[8'h00] == 8'h22, "R6 pointer wraps to 0x00", mem[8'h00], 8'h22);
    addr_sel = 1'b0;
  endtask

  task automatic t_abort;
    bit a; int w0;
    bus_start;
    send_byte(8'h38, a);
    send_byte(8'h40, a);
    w0 = we_cnt;
    send_bits(8'hC3, 4);
    bus_stop;
    check(we_cnt == w0 && mem[8'h40] == 8'h00, "R2 stop mid-byte drops byte", we_cnt - w0, 0);
    bus_start;
    send_byte(8'h38, a);
    send_byte(8'h50, a);
    send_bits(8'hE7, 3);
    bus_start;
    send_byte(8'h38, a); check(a, "R2 restart after mid-byte start", a, 1);
    send_byte(8'h60, a);
    send_byte(8'h33, a);
    bus_stop;
    check(mem[8'h50] == 8'h00, "R2 cut byte not written", mem[8'h50], 0);
    check(mem[8'h60] == 8'h33, "R2 write after restart", mem[8'h60], 8'h33);
    check(hi_changes == 0, "R9 sda_o steady while SCL high", hi_changes, 0);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_clk(5);
    t_reset;
    rst_n = 1'b1;
    wait_clk(5);
    t_write_lo;
    t_read;
    t_mismatch;
    t_sel_hi;
    t_abort;
    finish_sim;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim;
  end
endmodule